// File: doc/BRIEF.md
# Compare-Match Timer Channel

One channel of a 16-bit general-purpose timer, reached through a small byte-addressed register window. A prescaled tick advances a 16-bit counter. Each tick on which the counter equals the compare register is a match. A match can send the counter back to zero, which gives a periodic timer. It also drives a waveform output pin through a configurable action and sets a sticky match flag, and that flag raises a maskable, level-sensitive interrupt.

Counting is gated by a run input. That input is one bit of a start register shared by several channels, so run control sits outside the channel. Software typically stops the channel and programs the clock divider, the clear source, the pin action, the compare value and the counter. It then sets the run bit. The interrupt handler reads the status register and writes a zero to the flag bit to acknowledge the match.

Top module: `cmt_channel`

## Requirements
- R1: After reset every register reads 0, the interrupt output is 0 and the waveform pin is 0.
- R2: Registers sit at byte offsets: control 0, mode 1, pin control 2, interrupt enable 4, status 5 (bit 0 is the flag, the other bits read 0), counter 6 and compare 8. The counter and compare registers are written and read as 16 bits. The others are 8-bit registers held in data bits [7:0], and they read back what was written. Unused offsets read 0.
- R3: Control bits [2:0] select the tick rate: code 0 = every clock, 1 = every 4th, 2 = every 16th, 3 = every 64th. Codes 4 to 7 produce no ticks, so the counter holds.
- R4: The counter advances only while the run input is high and the mode register low nibble is 0. The divider phase returns to zero whenever counting is not enabled, so two separate 40-cycle runs at divide-by-64 produce no tick.
- R5: Control bits [7:5] select the clear source. With code 1, the counter value after a match is 0, giving a period of compare+1 ticks. With code 0, the counter runs freely and wraps from 0xFFFF to 0x0000.
- R6: The status flag is set on a match and stays set. It clears only when software writes data bit 0 = 0 to the status register after a status read that saw the flag set. Writing 1 leaves the flag as it is. Writing 0 without that prior read also leaves it as it is.
- R7: The interrupt output is high exactly while the flag is set and interrupt-enable bit 0 is 1.
- R8: The pin control low nibble sets the pin action. Code 0 or 4 keeps the pin level. Codes 1, 2 and 3 drive the pin low at once, and 5, 6 and 7 drive it high at once. After that, each match clears the pin (codes 1 and 5), sets it (2 and 6) or toggles it (3 and 7). Codes 8 and above take no action.
- R9: A counter write in the same clock cycle as a tick loads the written value, with no increment and no clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run_i | input | 1 | Run bit for this channel, taken from the shared start register |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset within the channel |
| bus_wdata_i | input | 16 | Write data; 8-bit registers use bits [7:0] |
| bus_rdata_o | output | 16 | Read data for the addressed register (combinational) |
| irq_o | output | 1 | Compare-match interrupt request (level) |
| toc_o | output | 1 | Compare waveform output pin |

## Verification
The bench targets the match boundary in periodic mode. A design that clears one tick late shows a period of compare+2, and the table of divider and compare settings exposes that as a wrong final count. It also checks the two-step flag acknowledge. A design that clears on any write of 0, or on a write of 1, drops an interrupt that software never saw. Other targets are restarting the divider on stop, where a design that keeps its phase produces a spurious tick across two short runs, and a counter write landing on a tick, where a design with the wrong priority reads back the written value plus one. Finally, a toggle sequence over three matches and a wrap from 0xFFFE show whether the pin action and the free-running rollover are right.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] OFS_MODE = 4'd1;
  localparam logic [ADDR_W-1:0] OFS_PIN  = 4'd2;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 4'd4;
  localparam logic [ADDR_W-1:0] OFS_STAT = 4'd5;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 4'd6;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 4'd8;

  localparam logic [2:0] CLR_CMPA    = 3'd1;
  localparam logic [3:0] MODE_NORMAL = 4'd0;

  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_LOW  = 2'd1,
    ACT_HIGH = 2'd2,
    ACT_FLIP = 2'd3
  } pin_act_e;

  // Match action: bits [1:0] pick the action, bit 3 disables it.
  function automatic pin_act_e act_of(input logic [3:0] code);
    if (code[3]) return ACT_KEEP;
    return pin_act_e'(code[1:0]);
  endfunction

endpackage

// File: rtl/cmt_rst_sync.sv
`timescale 1ns/1ps
module cmt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmt_prescaler.sv
`timescale 1ns/1ps
module cmt_prescaler #(
  parameter int unsigned SEL_W     = 3,
  parameter int unsigned DIV_STEPS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] code_i,
  output logic             tick_o
);
  localparam int unsigned PC_W = 2 * (DIV_STEPS - 1);
  localparam logic [SEL_W-1:0] STEPS_L = SEL_W'(DIV_STEPS);

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] pc_d;
  logic [PC_W-1:0] mask;
  logic            code_ok;

  // Divide by 4**code: a tick when the low 2*code phase bits are all ones.
  always_comb begin
    for (int i = 0; i < PC_W; i++) begin
      mask[i] = (i < 2 * int'(code_i));
    end
  end

  assign code_ok = (code_i < STEPS_L);
  assign tick_o  = en_i && code_ok && ((pc_q & mask) == mask);

  always_comb begin
    if (en_i) pc_d = pc_q + PC_W'(1);
    else      pc_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  // R4: stopping returns the divider to phase zero
  a_r4_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (pc_q == '0));

  // R3: reserved divider codes never tick
  a_r3_reserved_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (code_i >= STEPS_L) |-> !tick_o);
endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             we_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic             clr_on_match_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             match_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  assign match_o = tick_i && (cnt_q == cmp_i);
  assign cnt_o   = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (we_i)                           cnt_d = wdata_i;
    else if (match_o && clr_on_match_i) cnt_d = '0;
    else if (tick_i)                    cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: a counter write wins over counting and clearing
  a_r9_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (cnt_o == $past(wdata_i)));

  // R5: clear-on-match returns the counter to zero
  a_r5_clear_after_match: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && clr_on_match_i && !we_i) |=> (cnt_o == '0));

  // R4: no tick and no write means the counter holds
  a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !we_i) |=> $stable(cnt_o));
endmodule

// File: rtl/cmt_outpin.sv
`timescale 1ns/1ps
module cmt_outpin
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfg_we_i,
  input  logic [3:0] cfg_new_i,
  input  logic [3:0] cfg_q_i,
  input  logic       match_i,
  output logic       pin_o
);
  logic     pin_q;
  logic     pin_d;
  pin_act_e act;

  assign act = act_of(cfg_q_i);

  always_comb begin
    pin_d = pin_q;
    if (cfg_we_i) begin
      if (act_of(cfg_new_i) != ACT_KEEP) pin_d = cfg_new_i[2];
    end else if (match_i) begin
      unique case (act)
        ACT_LOW:  pin_d = 1'b0;
        ACT_HIGH: pin_d = 1'b1;
        ACT_FLIP: pin_d = ~pin_q;
        default:  pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= 1'b0;
    else        pin_q <= pin_d;
  end

  assign pin_o = pin_q;

  // R8: the pin moves only on a configuration write or a match
  a_r8_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_we_i && !match_i) |=> $stable(pin_o));

  // R8: the toggle action inverts the pin on each match
  a_r8_pin_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (match_i && !cfg_we_i && act == ACT_FLIP) |=> (pin_o != $past(pin_o)));
endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel
  import cmt_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_i,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [CNT_W-1:0]  bus_wdata_i,
  output logic [CNT_W-1:0]  bus_rdata_o,
  output logic              irq_o,
  output logic              toc_o
);
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PAD_W  = CNT_W - BYTE_W;

  logic rst_s_n;

  logic [BYTE_W-1:0] ctrl_q, ctrl_d;
  logic [BYTE_W-1:0] mode_q, mode_d;
  logic [BYTE_W-1:0] pin_q, pin_d;
  logic [BYTE_W-1:0] ien_q, ien_d;
  logic [CNT_W-1:0]  cmp_q, cmp_d;
  logic              flag_q, flag_d;
  logic              armed_q, armed_d;

  logic wr_ctrl, wr_mode, wr_pin, wr_ien, wr_stat, wr_cnt, wr_cmp, rd_stat;
  logic count_en, tick, match, clr_fire;
  logic [CNT_W-1:0] cnt;

  cmt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_s_n)
  );

  // Bus decode
  always_comb begin
    wr_ctrl = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_CTRL);
    wr_mode = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_MODE);
    wr_pin  = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_PIN);
    wr_ien  = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_IEN);
    wr_stat = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_STAT);
    wr_cnt  = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_CNT);
    wr_cmp  = bus_sel_i && bus_wr_i && (bus_addr_i == OFS_CMP);
    rd_stat = bus_sel_i && !bus_wr_i && (bus_addr_i == OFS_STAT);
  end

  assign count_en = run_i && (mode_q[3:0] == MODE_NORMAL);

  cmt_prescaler #(.SEL_W(3), .DIV_STEPS(4)) u_psc (
    .clk(clk), .rst_n(rst_s_n), .en_i(count_en),
    .code_i(ctrl_q[2:0]), .tick_o(tick)
  );

  cmt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_s_n), .tick_i(tick), .we_i(wr_cnt),
    .wdata_i(bus_wdata_i), .cmp_i(cmp_q),
    .clr_on_match_i(ctrl_q[7:5] == CLR_CMPA),
    .cnt_o(cnt), .match_o(match)
  );

  cmt_outpin u_pin (
    .clk(clk), .rst_n(rst_s_n), .cfg_we_i(wr_pin),
    .cfg_new_i(bus_wdata_i[3:0]), .cfg_q_i(pin_q[3:0]),
    .match_i(match), .pin_o(toc_o)
  );

  // Register next state
  always_comb begin
    ctrl_d = wr_ctrl ? bus_wdata_i[BYTE_W-1:0] : ctrl_q;
    mode_d = wr_mode ? bus_wdata_i[BYTE_W-1:0] : mode_q;
    pin_d  = wr_pin  ? bus_wdata_i[BYTE_W-1:0] : pin_q;
    ien_d  = wr_ien  ? bus_wdata_i[BYTE_W-1:0] : ien_q;
    cmp_d  = wr_cmp  ? bus_wdata_i : cmp_q;
  end

  // Flag: set by match, cleared by a zero write following a read that saw it
  assign clr_fire = wr_stat && !bus_wdata_i[0] && armed_q;

  always_comb begin
    flag_d  = flag_q;
    armed_d = armed_q;
    if (rd_stat && flag_q) armed_d = 1'b1;
    if (clr_fire) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (match) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      ctrl_q  <= '0;
      mode_q  <= '0;
      pin_q   <= '0;
      ien_q   <= '0;
      cmp_q   <= '0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      ctrl_q  <= ctrl_d;
      mode_q  <= mode_d;
      pin_q   <= pin_d;
      ien_q   <= ien_d;
      cmp_q   <= cmp_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  // Read mux
  always_comb begin
    unique case (bus_addr_i)
      OFS_CTRL: bus_rdata_o = {{PAD_W{1'b0}}, ctrl_q};
      OFS_MODE: bus_rdata_o = {{PAD_W{1'b0}}, mode_q};
      OFS_PIN:  bus_rdata_o = {{PAD_W{1'b0}}, pin_q};
      OFS_IEN:  bus_rdata_o = {{PAD_W{1'b0}}, ien_q};
      OFS_STAT: bus_rdata_o = {{(CNT_W-1){1'b0}}, flag_q};
      OFS_CNT:  bus_rdata_o = cnt;
      OFS_CMP:  bus_rdata_o = cmp_q;
      default:  bus_rdata_o = '0;
    endcase
  end

  assign irq_o = flag_q && ien_q[0];

  // R6: a match always leaves the flag set
  a_r6_set_on_match: assert property (@(posedge clk) disable iff (!rst_s_n)
    match |=> flag_q);

  // R6: without a prior read the flag cannot drop
  a_r6_no_clear_unarmed: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag_q && !armed_q) |=> flag_q);

  // R6: writing a one never clears the flag
  a_r6_one_no_effect: assert property (@(posedge clk) disable iff (!rst_s_n)
    (flag_q && wr_stat && bus_wdata_i[0]) |=> flag_q);

  // R7: the interrupt requires the flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq_o |-> flag_q);
endmodule

// File: tb/sim_cmt_channel.sv
`timescale 1ns/1ps
module sim_cmt_channel;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        sel = 1'b0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic        toc;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cmt_channel u0 (
    .clk(clk), .rst_n(rst_n), .run_i(run), .bus_sel_i(sel), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_o(irq), .toc_o(toc)
  );

  typedef struct packed {
    logic [2:0]  psc;
    logic [2:0]  clr;
    logic [15:0] cmp;
    logic [15:0] k;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 3'd0, 16'd100, 16'd37},
    '{3'd1, 3'd0, 16'd5,   16'd40},
    '{3'd2, 3'd0, 16'd3,   16'd70},
    '{3'd3, 3'd0, 16'd0,   16'd200},
    '{3'd0, 3'd1, 16'd9,   16'd25},
    '{3'd1, 3'd1, 16'd4,   16'd23},
    '{3'd4, 3'd0, 16'd2,   16'd30},
    '{3'd7, 3'd1, 16'd2,   16'd30},
    '{3'd2, 3'd1, 16'd7,   16'd64}
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 sel = 1'b0; wr = 1'b0;
  endtask

  task automatic br(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    @(posedge clk);
    #1 sel = 1'b0;
  endtask

  task automatic run_for(input int k);
    @(negedge clk) run = 1'b1;
    repeat (k) @(posedge clk);
    @(negedge clk) run = 1'b0;
  endtask

  task automatic ack_flag();
    logic [15:0] s;
    br(4'd5, s);
    bw(4'd5, 16'h0000);
  endtask

  // Requirement model: ticks = k / 4**psc, or none for reserved codes.
  function automatic int ticks_of(input logic [2:0] psc, input int k);
    if (psc > 3'd3) return 0;
    return k / (1 << (2 * int'(psc)));
  endfunction

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int t;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1: reset state
    br(4'd0, d); chk("R1 ctrl", d, 16'h0);
    br(4'd1, d); chk("R1 mode", d, 16'h0);
    br(4'd2, d); chk("R1 pinctl", d, 16'h0);
    br(4'd4, d); chk("R1 ien", d, 16'h0);
    br(4'd5, d); chk("R1 status", d, 16'h0);
    br(4'd6, d); chk("R1 counter", d, 16'h0);
    br(4'd8, d); chk("R1 compare", d, 16'h0);
    chk("R1 irq", {15'd0, irq}, 16'h0);
    chk("R1 pin", {15'd0, toc}, 16'h0);

    // R2: readback and map
    bw(4'd0, 16'h0023); br(4'd0, d); chk("R2 ctrl readback", d, 16'h0023);
    bw(4'd8, 16'hBEEF); br(4'd8, d); chk("R2 compare readback", d, 16'hBEEF);
    bw(4'd4, 16'h0081); br(4'd4, d); chk("R2 ien readback", d, 16'h0081);
    br(4'd3, d); chk("R2 unused offset", d, 16'h0);
    bw(4'd4, 16'h0001);

    // Table walk: R3, R5, R6, R7
    foreach (VECS[i]) begin
      bw(4'd0, {8'd0, VECS[i].clr, 2'b00, VECS[i].psc});
      bw(4'd8, VECS[i].cmp);
      bw(4'd6, 16'h0000);
      ack_flag();
      run_for(int'(VECS[i].k));
      t = ticks_of(VECS[i].psc, int'(VECS[i].k));
      br(4'd6, d);
      if (VECS[i].clr == 3'd1)
        chk($sformatf("R3 R5 vec%0d count", i), d, 16'(t % (int'(VECS[i].cmp) + 1)));
      else
        chk($sformatf("R3 R5 vec%0d count", i), d, 16'(t % 65536));
      br(4'd5, d);
      chk($sformatf("R6 vec%0d flag", i), d, {15'd0, t > int'(VECS[i].cmp)});
      chk($sformatf("R7 vec%0d irq", i), {15'd0, irq}, {15'd0, t > int'(VECS[i].cmp)});
    end

    // R5: free-running wrap
    bw(4'd0, 16'h0000); bw(4'd8, 16'h0005); bw(4'd6, 16'hFFFE);
    run_for(3);
    br(4'd6, d); chk("R5 wrap", d, 16'h0001);

    // R6: acknowledge protocol (flag set by wrap run? no: make one)
    ack_flag();
    bw(4'd8, 16'h0002); bw(4'd6, 16'h0000);
    run_for(5);
    bw(4'd5, 16'h0000);
    br(4'd5, d); chk("R6 zero without read keeps flag", d, 16'h0001);
    bw(4'd5, 16'h0001);
    br(4'd5, d); chk("R6 write one keeps flag", d, 16'h0001);
    bw(4'd5, 16'h0000);
    br(4'd5, d); chk("R6 read then zero clears", d, 16'h0000);
    chk("R7 irq low after clear", {15'd0, irq}, 16'h0);

    // R7: masking
    bw(4'd6, 16'h0000); run_for(5);
    bw(4'd4, 16'h0000);
    #1 chk("R7 masked irq", {15'd0, irq}, 16'h0);
    bw(4'd4, 16'h0001);
    #1 chk("R7 unmasked irq", {15'd0, irq}, 16'h1);
    ack_flag();

    // R4: mode gate
    bw(4'd1, 16'h0002); bw(4'd6, 16'h0000);
    run_for(10);
    br(4'd6, d); chk("R4 nonzero mode holds", d, 16'h0000);
    bw(4'd1, 16'h0000);

    // R4: divider phase restart
    bw(4'd0, 16'h0003); bw(4'd8, 16'hFFFF); bw(4'd6, 16'h0000);
    run_for(40); run_for(40);
    br(4'd6, d); chk("R4 divider restarts", d, 16'h0000);
    run_for(64);
    br(4'd6, d); chk("R4 full divide-by-64", d, 16'h0001);

    // R9: write priority over a tick
    bw(4'd0, 16'h0000); bw(4'd6, 16'h0000);
    @(negedge clk);
    run = 1'b1; sel = 1'b1; wr = 1'b1; addr = 4'd6; wdata = 16'h1234;
    @(posedge clk);
    #1 sel = 1'b0; wr = 1'b0;
    @(negedge clk) run = 1'b0;
    br(4'd6, d); chk("R9 write wins", d, 16'h1234);

    // R8: pin actions
    bw(4'd0, 16'h0020); bw(4'd8, 16'h0003); bw(4'd6, 16'h0000);
    bw(4'd2, 16'h0007);
    #1 chk("R8 code7 starts high", {15'd0, toc}, 16'h1);
    run_for(12);
    #1 chk("R8 three toggles", {15'd0, toc}, 16'h0);
    bw(4'd2, 16'h0002); bw(4'd6, 16'h0000);
    #1 chk("R8 code2 starts low", {15'd0, toc}, 16'h0);
    run_for(4);
    #1 chk("R8 set on match", {15'd0, toc}, 16'h1);
    bw(4'd2, 16'h0005); bw(4'd6, 16'h0000);
    #1 chk("R8 code5 starts high", {15'd0, toc}, 16'h1);
    run_for(4);
    #1 chk("R8 clear on match", {15'd0, toc}, 16'h0);
    bw(4'd2, 16'h0006);
    bw(4'd2, 16'h0000); bw(4'd6, 16'h0000);
    run_for(8);
    #1 chk("R8 code0 keeps level", {15'd0, toc}, 16'h1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule